// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one memory request from a group of sixteen lanes and turns it into the smallest set of memory transactions that the selected rule set allows. A group carries an active bit, a 32-bit byte address and a 2-bit access-size code for each lane. The block stores the group, works out the transactions it needs, and sends them out one at a time. Each transaction carries a base address, a byte count and the mask of lanes it serves. Both the group input and the transaction output use a valid/ready handshake.

Two rule sets are available. Strict rules merge a group only when every active lane k reads a 4-byte word at offset 4k inside one 64-byte aligned block. Any other pattern becomes one transaction per active lane. Relaxed rules collect the lanes by the 64-byte segments their bytes touch. They issue one transaction per distinct segment, from the lowest segment address to the highest. A new group is taken only after the last transaction of the current group has been accepted.

Top module: `hw_coalescer`

## Requirements
- R1: A group is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the edge that accepts the group's last transaction. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_base`, `tx_bytes` and `tx_lanes` hold their values.
- R2: In strict mode (`req_relaxed`=0), suppose every active lane has size code 2 (4 bytes) and lane k's address equals B+4k for one 64-byte aligned B. Then exactly one transaction is issued, with `tx_base`=B, `tx_bytes`=64 and `tx_lanes` equal to the active mask.
- R3: Inactive lanes, including lane 0, do not prevent the single-transaction merge of R2. Their addresses are ignored, and no transaction ever names a lane outside the active mask.
- R4: In strict mode, a permuted pattern inside one block is issued as one transaction per active lane. These go in ascending lane index, each with `tx_base` equal to the lane's address, `tx_bytes` equal to its size and a one-hot `tx_lanes`.
- R5: In strict mode, a start address not at offset 0 of a block, or a stride other than 4 bytes, also falls back to the per-lane transactions of R4.
- R6: Size codes map to bytes as 0→1, 1→2, 2→4, 3→12. A group using size code 3 is never merged in strict mode and costs one transaction per active lane.
- R7: In relaxed mode (`req_relaxed`=1), each transaction has a 64-byte aligned `tx_base` and `tx_bytes`=64. Any arrangement of active lanes inside one segment costs exactly one transaction, whose `tx_lanes` is the active mask.
- R8: In relaxed mode, a lane whose bytes cross a 64-byte boundary is served by both segments it touches. The transaction count equals the number of distinct segments touched, so a misaligned run costs one or two transactions.
- R9: In relaxed mode, transactions are issued in strictly ascending `tx_base` order, whatever the order of the lanes.
- R10: A group whose active mask is all zero issues no transaction, and `req_ready` is high again in the cycle after it is taken.
- R11: While `rst_n` is low, and right after reset, `tx_valid` is 0 and `req_ready` is 1. A transaction stream in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A group is offered |
| req_ready | output | 1 | The block can take a group |
| req_relaxed | input | 1 | 0 selects strict rules, 1 selects relaxed segment rules |
| req_mask | input | 16 | Active bit per lane |
| req_addr | input | 512 | Byte address per lane, lane i in bits [32i+31:32i] |
| req_size | input | 32 | Size code per lane, lane i in bits [2i+1:2i] |
| tx_valid | output | 1 | A transaction is offered |
| tx_ready | input | 1 | Downstream accepts the transaction |
| tx_base | output | 32 | Transaction base byte address |
| tx_bytes | output | 7 | Transaction length in bytes |
| tx_lanes | output | 16 | Lanes served by this transaction |

## Verification
The bound checker watches several rules on every cycle. It checks that no group is taken while transactions are pending, and that a stalled transaction stays stable. It also checks that every transaction names only active lanes, that relaxed transactions are segment-aligned and rise in address, that strict per-lane transactions are one-hot, and that an empty group frees the input at once. Other properties are only visible over a whole group, so only the bench scenarios can show them. These are the exact transaction count for permuted, misaligned, strided, 12-byte and boundary-crossing patterns, the base, length and mask of the first transaction, and the rule that the lanes served across a group add up to the active mask.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  localparam int SZ_CODE_W = 2;
  localparam logic [SZ_CODE_W-1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_BLOCK = 2'd1,
    K_LANE  = 2'd2,
    K_SEG   = 2'd3
  } kind_e;

  function automatic logic [7:0] size_bytes(input logic [SZ_CODE_W-1:0] code);
    case (code)
      2'd0:    size_bytes = 8'd1;
      2'd1:    size_bytes = 8'd2;
      2'd2:    size_bytes = 8'd4;
      default: size_bytes = 8'd12;
    endcase
  endfunction

endpackage

// File: rtl/hwc_strict_check.sv
module hwc_strict_check
  import hwc_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 64
) (
  input  logic [LANES-1:0]           mask,
  input  logic [LANES*AW-1:0]        addr,
  input  logic [LANES*SZ_CODE_W-1:0] size,
  output logic                       merge_ok
);
  localparam int SEG_LSB = $clog2(SEG_BYTES);
  localparam int BW      = AW - SEG_LSB;

  logic [BW-1:0] ref_blk;

  always_comb begin
    ref_blk = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) ref_blk = addr[i*AW+SEG_LSB +: BW];
    end
    merge_ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) begin
        if (size[i*SZ_CODE_W +: SZ_CODE_W] != SZ_WORD) merge_ok = 1'b0;
        if (addr[i*AW +: SEG_LSB] != SEG_LSB'(i * 4)) merge_ok = 1'b0;
        if (addr[i*AW+SEG_LSB +: BW] != ref_blk) merge_ok = 1'b0;
      end
    end
  end

endmodule

// File: rtl/hwc_seg_pick.sv
module hwc_seg_pick #(
  parameter int LANES = 16,
  parameter int SW    = 26
) (
  input  logic [LANES*SW-1:0] lo_seg,
  input  logic [LANES*SW-1:0] hi_seg,
  input  logic [LANES-1:0]    lo_need,
  input  logic [LANES-1:0]    hi_need,
  output logic [SW-1:0]       min_seg,
  output logic [LANES-1:0]    hit_lo,
  output logic [LANES-1:0]    hit_hi
);
  logic found;

  always_comb begin
    found   = 1'b0;
    min_seg = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lo_need[i] && (!found || lo_seg[i*SW +: SW] < min_seg)) begin
        min_seg = lo_seg[i*SW +: SW];
        found   = 1'b1;
      end
      if (hi_need[i] && (!found || hi_seg[i*SW +: SW] < min_seg)) begin
        min_seg = hi_seg[i*SW +: SW];
        found   = 1'b1;
      end
    end
    for (int i = 0; i < LANES; i++) begin
      hit_lo[i] = lo_need[i] && (lo_seg[i*SW +: SW] == min_seg);
      hit_hi[i] = hi_need[i] && (hi_seg[i*SW +: SW] == min_seg);
    end
  end

endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
  import hwc_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_relaxed,
  input  logic [LANES-1:0]              req_mask,
  input  logic [LANES*AW-1:0]           req_addr,
  input  logic [LANES*SZ_CODE_W-1:0]    req_size,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [AW-1:0]                 tx_base,
  output logic [$clog2(SEG_BYTES):0]    tx_bytes,
  output logic [LANES-1:0]              tx_lanes
);
  localparam int SEG_LSB = $clog2(SEG_BYTES);
  localparam int SW      = AW - SEG_LSB;
  localparam int LW      = $clog2(LANES);
  localparam int TBW     = SEG_LSB + 1;

  // Segment holding the last byte of an access.
  function automatic logic [SW-1:0] end_seg(input logic [AW-1:0] a,
                                            input logic [SZ_CODE_W-1:0] c);
    logic [AW-1:0] e;
    e = a + {{(AW-8){1'b0}}, size_bytes(c)} - 1'b1;
    return e[AW-1:SEG_LSB];
  endfunction

  // Lowest set bit as a one-hot vector.
  function automatic logic [LANES-1:0] lowest_one(input logic [LANES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  kind_e                        kind_q;
  logic [LANES*AW-1:0]          addr_q;
  logic [LANES*SZ_CODE_W-1:0]   size_q;
  logic [LANES-1:0]             lo_need_q, hi_need_q;

  // Named events for the checker.
  logic                         accept_grp, accept_tx, busy;
  logic                         merge_ok;
  logic [LANES-1:0]             straddle_in;
  logic [LANES*SW-1:0]          lo_seg, hi_seg;
  logic [SW-1:0]                min_seg;
  logic [LANES-1:0]             hit_lo, hit_hi, lane_pick;
  logic [LW-1:0]                pick_idx;
  logic [LANES-1:0]             lo_left, hi_left;

  assign busy       = (kind_q != K_IDLE);
  assign req_ready  = !busy;
  assign tx_valid   = busy;
  assign accept_grp = req_valid && req_ready;
  assign accept_tx  = tx_valid && tx_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign straddle_in[g] =
      end_seg(req_addr[g*AW +: AW], req_size[g*SZ_CODE_W +: SZ_CODE_W])
      != req_addr[g*AW+SEG_LSB +: SW];
    assign lo_seg[g*SW +: SW] = addr_q[g*AW+SEG_LSB +: SW];
    assign hi_seg[g*SW +: SW] =
      end_seg(addr_q[g*AW +: AW], size_q[g*SZ_CODE_W +: SZ_CODE_W]);
  end

  hwc_strict_check #(.LANES(LANES), .AW(AW), .SEG_BYTES(SEG_BYTES)) u_strict (
    .mask     (req_mask),
    .addr     (req_addr),
    .size     (req_size),
    .merge_ok (merge_ok)
  );

  hwc_seg_pick #(.LANES(LANES), .SW(SW)) u_pick (
    .lo_seg  (lo_seg),
    .hi_seg  (hi_seg),
    .lo_need (lo_need_q),
    .hi_need (hi_need_q),
    .min_seg (min_seg),
    .hit_lo  (hit_lo),
    .hit_hi  (hit_hi)
  );

  always_comb begin
    pick_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lo_need_q[i]) pick_idx = LW'(i);
    end
  end
  assign lane_pick = lowest_one(lo_need_q);

  always_comb begin
    tx_base  = '0;
    tx_bytes = '0;
    tx_lanes = '0;
    lo_left  = lo_need_q;
    hi_left  = hi_need_q;
    case (kind_q)
      K_BLOCK: begin
        tx_base  = {addr_q[pick_idx*AW+SEG_LSB +: SW], {SEG_LSB{1'b0}}};
        tx_bytes = TBW'(SEG_BYTES);
        tx_lanes = lo_need_q;
        lo_left  = '0;
      end
      K_LANE: begin
        tx_base  = addr_q[pick_idx*AW +: AW];
        tx_bytes = TBW'(size_bytes(size_q[pick_idx*SZ_CODE_W +: SZ_CODE_W]));
        tx_lanes = lane_pick;
        lo_left  = lo_need_q & ~lane_pick;
      end
      K_SEG: begin
        tx_base  = {min_seg, {SEG_LSB{1'b0}}};
        tx_bytes = TBW'(SEG_BYTES);
        tx_lanes = hit_lo | hit_hi;
        lo_left  = lo_need_q & ~hit_lo;
        hi_left  = hi_need_q & ~hit_hi;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= K_IDLE;
      addr_q    <= '0;
      size_q    <= '0;
      lo_need_q <= '0;
      hi_need_q <= '0;
    end else if (accept_grp) begin
      addr_q    <= req_addr;
      size_q    <= req_size;
      lo_need_q <= req_mask;
      hi_need_q <= req_relaxed ? (req_mask & straddle_in) : '0;
      if (req_mask == '0)   kind_q <= K_IDLE;
      else if (req_relaxed) kind_q <= K_SEG;
      else if (merge_ok)    kind_q <= K_BLOCK;
      else                  kind_q <= K_LANE;
    end else if (accept_tx) begin
      lo_need_q <= lo_left;
      hi_need_q <= hi_left;
      if (lo_left == '0 && hi_left == '0) kind_q <= K_IDLE;
    end
  end

endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int LANES     = 16,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_ready,
  input logic                       req_relaxed,
  input logic [LANES-1:0]           req_mask,
  input logic                       tx_valid,
  input logic                       tx_ready,
  input logic [AW-1:0]              tx_base,
  input logic [$clog2(SEG_BYTES):0] tx_bytes,
  input logic [LANES-1:0]           tx_lanes,
  input logic                       accept_grp,
  input logic                       accept_tx
);
  localparam int SEG_LSB = $clog2(SEG_BYTES);

  logic [LANES-1:0] mask_q;
  logic             relaxed_q, seen_q;
  logic [AW-1:0]    prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      relaxed_q <= 1'b0;
      seen_q    <= 1'b0;
      prev_q    <= '0;
    end else if (accept_grp) begin
      mask_q    <= req_mask;
      relaxed_q <= req_relaxed;
      seen_q    <= 1'b0;
    end else if (accept_tx) begin
      prev_q <= tx_base;
      seen_q <= 1'b1;
    end
  end

  assert_no_new_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  assert_hold_when_stalled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) && $stable(tx_bytes)
                              && $stable(tx_lanes));

  assert_lanes_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_lanes != '0) && ((tx_lanes & ~mask_q) == '0));

  assert_lane_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !relaxed_q && (tx_bytes != SEG_BYTES) |-> $countones(tx_lanes) == 1);

  assert_seg_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && relaxed_q |-> (tx_base[SEG_LSB-1:0] == '0) && (tx_bytes == SEG_BYTES));

  assert_ascending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && relaxed_q && seen_q |-> tx_base > prev_q);

  assert_empty_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_grp && (req_mask == '0) |=> req_ready && !tx_valid);

endmodule

bind hw_coalescer hwc_checker #(.LANES(LANES), .AW(AW), .SEG_BYTES(SEG_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .req_relaxed (req_relaxed),
  .req_mask    (req_mask),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_base     (tx_base),
  .tx_bytes    (tx_bytes),
  .tx_lanes    (tx_lanes),
  .accept_grp  (accept_grp),
  .accept_tx   (accept_tx)
);

// File: tb/test_hw_coalescer.sv
`timescale 1ns/1ps
module test_hw_coalescer;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   req_valid = 1'b0;
  logic                   req_ready;
  logic                   req_relaxed = 1'b0;
  logic [LANES-1:0]       req_mask = '0;
  logic [LANES*AW-1:0]    req_addr = '0;
  logic [LANES*2-1:0]     req_size = '0;
  logic                   tx_valid;
  logic                   tx_ready = 1'b0;
  logic [AW-1:0]          tx_base;
  logic [6:0]             tx_bytes;
  logic [LANES-1:0]       tx_lanes;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  hw_coalescer i_hw_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_relaxed(req_relaxed), .req_mask(req_mask), .req_addr(req_addr),
    .req_size(req_size), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_base(tx_base), .tx_bytes(tx_bytes), .tx_lanes(tx_lanes)
  );

  typedef struct packed {
    logic        rlx;
    logic [15:0] mask;
    logic [31:0] start;
    logic [7:0]  stride;
    logic        rev;
    logic [1:0]  szc;
    logic [7:0]  n;
    logic [31:0] base0;
    logic [15:0] lanes0;
    logic [7:0]  bytes0;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{1'b0, 16'hFFFF, 32'h080,  8'd4,  1'b0, 2'd2, 8'd1,  32'h080,  16'hFFFF, 8'd64},
    '{1'b0, 16'hF0F5, 32'h100,  8'd4,  1'b0, 2'd2, 8'd1,  32'h100,  16'hF0F5, 8'd64},
    '{1'b0, 16'hFFFF, 32'h080,  8'd4,  1'b1, 2'd2, 8'd16, 32'h0BC,  16'h0001, 8'd4},
    '{1'b0, 16'hFFFF, 32'h084,  8'd4,  1'b0, 2'd2, 8'd16, 32'h084,  16'h0001, 8'd4},
    '{1'b0, 16'hFFFF, 32'h200,  8'd8,  1'b0, 2'd2, 8'd16, 32'h200,  16'h0001, 8'd4},
    '{1'b0, 16'hFFFF, 32'h300,  8'd12, 1'b0, 2'd3, 8'd16, 32'h300,  16'h0001, 8'd12},
    '{1'b1, 16'hFFFF, 32'h080,  8'd4,  1'b1, 2'd2, 8'd1,  32'h080,  16'hFFFF, 8'd64},
    '{1'b1, 16'hFFFF, 32'h084,  8'd4,  1'b0, 2'd2, 8'd2,  32'h080,  16'h7FFF, 8'd64},
    '{1'b1, 16'hFFFF, 32'h082,  8'd1,  1'b0, 2'd0, 8'd1,  32'h080,  16'hFFFF, 8'd64},
    '{1'b1, 16'hFFFF, 32'h084,  8'd4,  1'b1, 2'd2, 8'd2,  32'h080,  16'hFFFE, 8'd64},
    '{1'b1, 16'hFFFF, 32'h03E,  8'd64, 1'b0, 2'd2, 8'd17, 32'h000,  16'h0001, 8'd64},
    '{1'b0, 16'h0000, 32'h080,  8'd4,  1'b0, 2'd2, 8'd0,  32'h000,  16'h0000, 8'd0},
    '{1'b1, 16'hFFFF, 32'h1000, 8'd64, 1'b0, 2'd3, 8'd16, 32'h1000, 16'h0001, 8'd64},
    '{1'b0, 16'hFFFE, 32'h140,  8'd4,  1'b0, 2'd2, 8'd1,  32'h140,  16'hFFFE, 8'd64}
  };

  function automatic string tag_of(int v);
    case (v)
      0:       return "R2";
      1, 13:   return "R3";
      2:       return "R4";
      3, 4:    return "R5";
      5:       return "R6";
      6, 12:   return "R7";
      7, 8, 10: return "R8";
      9:       return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic load_group(vec_t e);
    req_relaxed = e.rlx;
    req_mask    = e.mask;
    for (int k = 0; k < LANES; k++) begin
      logic [31:0] off;
      off = e.rev ? e.stride * (15 - k) : e.stride * k;
      req_addr[k*AW +: AW] = e.start + off;
      req_size[k*2 +: 2]   = e.szc;
    end
  endtask

  task automatic run_vec(int v);
    vec_t        e;
    string       t;
    int          cnt, guard;
    logic [15:0] uni;
    logic [31:0] prev;
    bit          ordered;
    e = VT[v];
    t = tag_of(v);
    @(negedge clk);
    load_group(e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (e.n > 0) chk(req_ready == 1'b0, "R1", "ready while pending", req_ready, 0);
    else         chk(req_ready == 1'b1, "R10", "ready after empty group", req_ready, 1);
    cnt = 0; guard = 0; uni = '0; prev = '0; ordered = 1'b1;
    while (guard < 400) begin
      if (!tx_valid && req_ready) break;
      tx_ready = (guard % 3 != 1);
      if (tx_valid && tx_ready) begin
        if (cnt == 0) begin
          chk(tx_base == e.base0, t, "first base", tx_base, e.base0);
          chk(tx_lanes == e.lanes0, t, "first lanes", tx_lanes, e.lanes0);
          chk(tx_bytes == e.bytes0[6:0], t, "first bytes", tx_bytes, e.bytes0);
        end else if (e.rlx && tx_base <= prev) begin
          ordered = 1'b0;
        end
        prev = tx_base;
        uni  = uni | tx_lanes;
        cnt++;
      end
      @(negedge clk);
      guard++;
    end
    tx_ready = 1'b0;
    chk(guard < 400, t, "group finished", guard, 400);
    chk(cnt == int'(e.n), t, "transaction count", cnt, e.n);
    chk(uni == e.mask, t, "lanes served", uni, e.mask);
    if (e.rlx) chk(ordered, "R9", "ascending bases", ordered, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R11", "tx_valid in reset", tx_valid, 0);
    chk(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid == 1'b0 && req_ready == 1'b1, "R11", "idle after reset",
        {tx_valid, req_ready}, 2'b01);

    for (int v = 0; v < NV; v++) run_vec(v);

    // Reset in the middle of a per-lane stream drops it.
    @(negedge clk);
    load_group(VT[2]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tx_valid == 1'b1, "R4", "stream started", tx_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tx_valid == 1'b0 && req_ready == 1'b1, "R11", "stream dropped by reset",
        {tx_valid, req_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule